// File: doc/BRIEF.md
# Ganged Dual-Lane Vector Executor

This block runs one 256-bit vector micro-op without a native 256-bit datapath. Two existing 128-bit datapaths of different construction work as a pair: the integer-style lane computes the low half of the result and the second lane, built like a floating-point stage, computes the high half in the same cycle. Neither lane grows wider. Supported operations are packed 32-bit addition, packed 32-bit multiplication keeping the low 32 bits of each product, and an element shuffle. The shuffle runs on a separate crossbar, because it is the only operation that moves data from one half to the other.

When the issuer does not need the full width, it can send a 128-bit op to either lane by itself. A narrow multiply holds only its own lane, and the other lane stays free for work. One issue port feeds the unit, and one result port returns each result together with the tag it was issued with. A stall output tells the issuer that the op now on the port cannot be taken in this cycle. The reason is either a lane that is still busy or a result slot that an in-flight multiply has already claimed.

Top module: `gsx_gang_exec`

## Requirements
- R1: A wide add (in_op=0, in_wide=1) returns, one cycle after acceptance, out_valid=1, out_wide=1 and a result whose element i (bits 32i+31..32i, i=0..7) is the sum modulo 2^32 of element i of A and B.
- R2: A wide multiply (in_op=1) returns its result three cycles after acceptance and not earlier, with each 32-bit element equal to the low 32 bits of the product of the matching A and B elements.
- R3: A shuffle (in_op=2) returns one cycle after acceptance. Result element i equals A element k, where k is in_sel[3i+2:3i], so an element can move between halves. The op is always full width (out_wide=1, out_lane=0) whatever in_wide and in_lane hold.
- R4: Every result carries the in_tag value of its op unchanged.
- R5: A narrow op (in_wide=0) runs on the lane chosen by in_lane (0 = low, 1 = high) using bits 127..0 of A and B. Its result appears in bits 127..0, bits 255..128 are zero and out_lane equals in_lane.
- R6: In the two cycles after a narrow multiply is accepted, an add or multiply that needs that lane (any wide one, or a narrow one with the same in_lane) is stalled. A narrow op to the other lane is not stalled.
- R7: A one-cycle op whose result would land in the same cycle as an in-flight multiply is stalled. Back-to-back results never collide.
- R8: A stalled op is not accepted. Holding it on the port until the stall drops produces exactly one result.
- R9: in_op=3 is ignored. It never stalls and produces no result.
- R10: During and right after reset, out_valid and in_stall are low.
- R11: Wide multiplies can be accepted on consecutive cycles, and their results come out on consecutive cycles in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An op is offered on the issue port |
| in_op | input | 2 | 0 add, 1 multiply, 2 shuffle, 3 ignored |
| in_wide | input | 1 | 1 = 256-bit ganged op, 0 = 128-bit op |
| in_lane | input | 1 | Lane for a narrow op |
| in_tag | input | 6 | Destination tag |
| in_a | input | 256 | Operand A |
| in_b | input | 256 | Operand B |
| in_sel | input | 24 | Eight 3-bit shuffle selectors |
| in_stall | output | 1 | Offered op cannot be taken this cycle |
| out_valid | output | 1 | Result present |
| out_tag | output | 6 | Tag of the result |
| out_wide | output | 1 | Result is full width |
| out_lane | output | 1 | Lane of a narrow result |
| out_data | output | 256 | Result data |

## Verification
The assertions check several things on every cycle. No two pipelines present a result in the same cycle. Adds and shuffles answer exactly one cycle after acceptance and carry their tag. The upper half of a narrow result is zero. A lane that holds a narrow multiply blocks any op that needs it. The ignored opcode never raises a stall. The arithmetic and shuffle values, the three-cycle multiply timing, the release of a held op after a slot conflict, and the ordering of back-to-back multiplies can only be shown by the bench's directed scenarios, which compare each result against values computed from the requirements.

// File: rtl/gsx_pkg.sv
// Shared constants and types for the ganged vector executor.
// Assumes two lanes of equal width; all widths derive from the element
// width and the number of elements per lane.
package gsx_pkg;
    localparam int ELEM_W     = 32;
    localparam int HALF_ELEMS = 4;
    localparam int TAG_W      = 6;
    localparam int LAT_ALU    = 1;
    localparam int LAT_MUL    = 3;
    localparam int NUM_ELEMS  = 2 * HALF_ELEMS;
    localparam int HALF_W     = ELEM_W * HALF_ELEMS;
    localparam int VEC_W      = 2 * HALF_W;
    localparam int SEL_IDX_W  = $clog2(NUM_ELEMS);
    localparam int SEL_W      = NUM_ELEMS * SEL_IDX_W;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MUL  = 2'd1,
        OP_SHF  = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef struct packed {
        logic             vld;
        op_e              op;
        logic             wide;
        logic             lane;
        logic [TAG_W-1:0] tag;
    } meta_t;
endpackage

// File: rtl/gsx_lane_dp.sv
// One 128-bit datapath: packed add (one register) and packed low-half
// multiply (MUL_STAGES registers). REG_FIRST picks the pipeline shape:
// 0 multiplies before the first register, 1 registers the operands first.
// Assumes MUL_STAGES >= 2. Enables only gate loads; metadata lives outside.
module gsx_lane_dp #(
    parameter int EW         = gsx_pkg::ELEM_W,
    parameter int NE         = gsx_pkg::HALF_ELEMS,
    parameter int MUL_STAGES = gsx_pkg::LAT_MUL,
    parameter bit REG_FIRST  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic             mul_en,
    input  logic [EW*NE-1:0] a,
    input  logic [EW*NE-1:0] b,
    output logic [EW*NE-1:0] add_q,
    output logic [EW*NE-1:0] mul_q
);
    localparam int W = EW * NE;

    function automatic logic [W-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] r;
        for (int i = 0; i < NE; i++) r[i*EW +: EW] = x[i*EW +: EW] + y[i*EW +: EW];
        return r;
    endfunction

    function automatic logic [W-1:0] f_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] r;
        for (int i = 0; i < NE; i++) r[i*EW +: EW] = x[i*EW +: EW] * y[i*EW +: EW];
        return r;
    endfunction

    logic [W-1:0] head;
    logic [W-1:0] st [1:MUL_STAGES-1];

    // Add result register, loaded only when this lane runs an add.
    always_ff @(posedge clk) begin
        if (!rst_n) add_q <= '0;
        else if (add_en) add_q <= f_add(a, b);
    end

    generate
        if (REG_FIRST) begin : g_opnd_first
            logic [W-1:0] ra, rb;
            // Capture operands; the product is formed in the next stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ra <= '0;
                    rb <= '0;
                end else if (mul_en) begin
                    ra <= a;
                    rb <= b;
                end
            end
            assign head = f_mul(ra, rb);
        end else begin : g_prod_first
            // Form the product before the first register.
            always_ff @(posedge clk) begin
                if (!rst_n) head <= '0;
                else if (mul_en) head <= f_mul(a, b);
            end
        end
    endgenerate

    // Remaining delay stages so both lane shapes share one latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 1; k < MUL_STAGES; k++) st[k] <= '0;
        end else begin
            st[1] <= head;
            for (int k = 2; k < MUL_STAGES; k++) st[k] <= st[k-1];
        end
    end

    assign mul_q = st[MUL_STAGES-1];
endmodule

// File: rtl/gsx_xbar.sv
// Cross-half shuffle network: each output element takes any source
// element of the full vector, then one register stage.
module gsx_xbar #(
    parameter int EW = gsx_pkg::ELEM_W,
    parameter int NE = gsx_pkg::NUM_ELEMS,
    localparam int IW = $clog2(NE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [EW*NE-1:0] src,
    input  logic [IW*NE-1:0] sel,
    output logic [EW*NE-1:0] q
);
    // Route every selected element into its destination slot.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (en) begin
            for (int i = 0; i < NE; i++)
                q[i*EW +: EW] <= src[int'(sel[i*IW +: IW])*EW +: EW];
        end
    end
endmodule

// File: rtl/gsx_issue_ctl.sv
// Issue admission. It tracks result slots claimed by in-flight multiplies
// and the lanes held by narrow multiplies, and raises a stall for an op
// that would collide with either. Assumes LAT_MUL >= 2 and that only
// multiplies outlive the cycle after they issue.
module gsx_issue_ctl #(
    parameter int LAT_ALU = gsx_pkg::LAT_ALU,
    parameter int LAT_MUL = gsx_pkg::LAT_MUL,
    localparam int CNT_W  = $clog2(LAT_MUL)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  gsx_pkg::op_e op,
    input  logic         wide,
    input  logic         lane,
    output logic         stall,
    output logic         accept
);
    import gsx_pkg::*;

    logic [LAT_MUL-1:1] occ;
    logic [1:0]         busy;
    logic               slot_clash;
    logic               lane_clash;
    int                 lat;

    // Latency of the offered op.
    always_comb lat = (op == OP_MUL) ? LAT_MUL : LAT_ALU;

    // A slot clash means an in-flight result already owns that output edge.
    always_comb begin
        slot_clash = 1'b0;
        for (int k = 1; k < LAT_MUL; k++)
            if (lat == k && occ[k]) slot_clash = 1'b1;
    end

    // Lanes matter only to adds and multiplies; the shuffle has its own network.
    always_comb begin
        if (op == OP_SHF) lane_clash = 1'b0;
        else if (wide)    lane_clash = |busy;
        else              lane_clash = busy[lane];
    end

    assign stall  = in_valid && (op != OP_NONE) && (slot_clash || lane_clash);
    assign accept = in_valid && (op != OP_NONE) && !stall;

    // Shift slot claims toward the output; a new op claims its landing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else begin
            for (int k = 1; k < LAT_MUL; k++)
                occ[k] <= ((k < LAT_MUL-1) ? occ[k+1 < LAT_MUL ? k+1 : k] : 1'b0)
                          || (accept && lat == k+1);
        end
    end

    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane_hold
            logic [CNT_W-1:0] cnt;
            // Hold a lane while its narrow multiply is still in flight.
            always_ff @(posedge clk) begin
                if (!rst_n) cnt <= '0;
                else if (accept && op == OP_MUL && !wide && lane == g)
                    cnt <= CNT_W'(LAT_MUL-1);
                else if (cnt != '0)
                    cnt <= cnt - 1'b1;
            end
            assign busy[g] = (cnt != '0);
        end
    endgenerate
endmodule

// File: rtl/gsx_gang_exec.sv
// Top of the ganged executor. A wide add or multiply uses both lanes in the
// same cycle (low half on lane 0, high half on lane 1); a narrow op uses the
// low operand halves on the lane it names. Shuffles use the crossbar.
// Metadata travels in pipes that match each latency, and the admission
// logic guarantees at most one result per cycle.
module gsx_gang_exec #(
    parameter int TAG_W = gsx_pkg::TAG_W,
    parameter int VEC_W = gsx_pkg::VEC_W,
    parameter int SEL_W = gsx_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic             in_wide,
    input  logic             in_lane,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    input  logic [SEL_W-1:0] in_sel,
    output logic             in_stall,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_wide,
    output logic             out_lane,
    output logic [VEC_W-1:0] out_data
);
    import gsx_pkg::*;
    localparam int HW = VEC_W / 2;

    op_e   op;
    logic  accept;
    meta_t m_alu;
    meta_t m_mul [LAT_MUL];
    meta_t o_meta;
    logic  alu_vld_w, mul_vld_w;
    logic [HW-1:0] lane_add_q [2];
    logic [HW-1:0] lane_mul_q [2];
    logic [VEC_W-1:0] xq;

    assign op = op_e'(in_op);

    gsx_issue_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op       (op),
        .wide     (in_wide),
        .lane     (in_lane),
        .stall    (in_stall),
        .accept   (accept)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            logic [HW-1:0] la, lb;
            logic          use_me;
            assign la     = in_wide ? in_a[g*HW +: HW] : in_a[HW-1:0];
            assign lb     = in_wide ? in_b[g*HW +: HW] : in_b[HW-1:0];
            assign use_me = accept && (in_wide || in_lane == g);
            gsx_lane_dp #(.REG_FIRST(g == 1)) u_dp (
                .clk    (clk),
                .rst_n  (rst_n),
                .add_en (use_me && op == OP_ADD),
                .mul_en (use_me && op == OP_MUL),
                .a      (la),
                .b      (lb),
                .add_q  (lane_add_q[g]),
                .mul_q  (lane_mul_q[g])
            );
        end
    endgenerate

    gsx_xbar u_xbar (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (accept && op == OP_SHF),
        .src   (in_a),
        .sel   (in_sel),
        .q     (xq)
    );

    // One-cycle metadata for adds and shuffles.
    always_ff @(posedge clk) begin
        if (!rst_n) m_alu <= '0;
        else begin
            m_alu.vld  <= accept && (op == OP_ADD || op == OP_SHF);
            m_alu.op   <= op;
            m_alu.wide <= in_wide || op == OP_SHF;
            m_alu.lane <= in_lane && !in_wide && op != OP_SHF;
            m_alu.tag  <= in_tag;
        end
    end

    // Multiply metadata pipe, one entry per multiply stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT_MUL; k++) m_mul[k] <= '0;
        end else begin
            m_mul[0].vld  <= accept && op == OP_MUL;
            m_mul[0].op   <= OP_MUL;
            m_mul[0].wide <= in_wide;
            m_mul[0].lane <= in_lane && !in_wide;
            m_mul[0].tag  <= in_tag;
            for (int k = 1; k < LAT_MUL; k++) m_mul[k] <= m_mul[k-1];
        end
    end

    assign alu_vld_w = m_alu.vld;
    assign mul_vld_w = m_mul[LAT_MUL-1].vld;
    assign o_meta    = alu_vld_w ? m_alu : m_mul[LAT_MUL-1];

    // Assemble the presented result from the lane halves or the crossbar.
    always_comb begin
        out_data = '0;
        case (o_meta.op)
            OP_SHF: out_data = xq;
            OP_ADD: out_data = o_meta.wide ? {lane_add_q[1], lane_add_q[0]}
                             : {{HW{1'b0}}, o_meta.lane ? lane_add_q[1] : lane_add_q[0]};
            OP_MUL: out_data = o_meta.wide ? {lane_mul_q[1], lane_mul_q[0]}
                             : {{HW{1'b0}}, o_meta.lane ? lane_mul_q[1] : lane_mul_q[0]};
            default: out_data = '0;
        endcase
    end

    assign out_valid = o_meta.vld;
    assign out_tag   = o_meta.tag;
    assign out_wide  = o_meta.wide;
    assign out_lane  = o_meta.lane;
endmodule

// File: rtl/gsx_gang_exec_chk.sv
// Property checker for gsx_gang_exec, attached with bind. It watches the
// ports and the two pipeline-presentation flags.
module gsx_gang_exec_chk #(
    parameter int TAG_W = gsx_pkg::TAG_W,
    parameter int VEC_W = gsx_pkg::VEC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_op,
    input logic             in_wide,
    input logic             in_lane,
    input logic [TAG_W-1:0] in_tag,
    input logic             in_stall,
    input logic             out_valid,
    input logic [TAG_W-1:0] out_tag,
    input logic             out_wide,
    input logic [VEC_W-1:0] out_data,
    input logic             alu_vld,
    input logic             mul_vld
);
    logic acc;
    assign acc = in_valid && in_op != 2'd3 && !in_stall;

    // R7: the one-cycle pipe and the multiply pipe never present together
    a_r7_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(alu_vld && mul_vld));

    // R1 and R4: an accepted add answers on the next cycle with its tag
    a_r1_add_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 2'd0) |=> (out_valid && out_tag == $past(in_tag)
                                    && out_wide == $past(in_wide)));

    // R3: an accepted shuffle answers on the next cycle at full width
    a_r3_shuffle_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 2'd2) |=> (out_valid && out_wide && out_tag == $past(in_tag)));

    // R5: narrow results leave the upper half clear
    a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_data[VEC_W-1:VEC_W/2] == '0));

    // R6: the cycle after a narrow multiply, ops needing that lane are held off
    a_r6_lane_held: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 2'd1 && !in_wide) |=>
        (!(in_valid && (in_op == 2'd0 || in_op == 2'd1)
           && (in_wide || in_lane == $past(in_lane))) || in_stall));

    // R9: the unused opcode never stalls
    a_r9_unused_op_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd3) |-> !in_stall);

    // R8: a stall only ever refers to an offered op
    a_r8_stall_needs_offer: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !in_stall);
endmodule

bind gsx_gang_exec gsx_gang_exec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_wide   (in_wide),
    .in_lane   (in_lane),
    .in_tag    (in_tag),
    .in_stall  (in_stall),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_wide  (out_wide),
    .out_data  (out_data),
    .alu_vld   (alu_vld_w),
    .mul_vld   (mul_vld_w)
);

// File: tb/gsx_gang_exec_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module gsx_gang_exec_tb;
    localparam logic [1:0] OPA = 2'd0, OPM = 2'd1, OPS = 2'd2, OPX = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   in_op;
    logic         in_wide, in_lane;
    logic [5:0]   in_tag;
    logic [255:0] in_a, in_b;
    logic [23:0]  in_sel;
    logic         in_stall, out_valid, out_wide, out_lane;
    logic [5:0]   out_tag;
    logic [255:0] out_data;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    gsx_gang_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_lane(in_lane), .in_tag(in_tag), .in_a(in_a),
        .in_b(in_b), .in_sel(in_sel), .in_stall(in_stall), .out_valid(out_valid),
        .out_tag(out_tag), .out_wide(out_wide), .out_lane(out_lane),
        .out_data(out_data)
    );

    function automatic logic [255:0] mk_vec(input int seed);
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = 32'(seed * (i + 3)) * 32'h9E3779B1 + 32'hF000_0000;
        return v;
    endfunction

    function automatic logic [255:0] e_add(input logic [255:0] x, input logic [255:0] y, input int n);
        logic [255:0] r = '0;
        for (int i = 0; i < n; i++) r[i*32 +: 32] = x[i*32 +: 32] + y[i*32 +: 32];
        return r;
    endfunction

    function automatic logic [255:0] e_mul(input logic [255:0] x, input logic [255:0] y, input int n);
        logic [255:0] r = '0;
        logic [63:0]  p;
        for (int i = 0; i < n; i++) begin
            p = {32'd0, x[i*32 +: 32]} * {32'd0, y[i*32 +: 32]};
            r[i*32 +: 32] = p[31:0];
        end
        return r;
    endfunction

    function automatic logic [255:0] e_shf(input logic [255:0] x, input logic [23:0] s);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = x[int'(s[i*3 +: 3])*32 +: 32];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put(input logic [1:0] op, input logic w, input logic ln, input logic [5:0] tg,
                       input logic [255:0] a, input logic [255:0] b, input logic [23:0] s);
        in_valid = 1'b1; in_op = op; in_wide = w; in_lane = ln; in_tag = tg;
        in_a = a; in_b = b; in_sel = s;
    endtask

    task automatic clr();
        in_valid = 1'b0;
    endtask

    task automatic check_result(input string req, input logic [5:0] tg, input logic w,
                                input logic ln, input logic [255:0] exp);
        chk(out_valid === 1'b1, req, "valid", 256'(out_valid), 256'd1);
        chk(out_tag === tg, req, "tag", 256'(out_tag), 256'(tg));
        chk(out_wide === w && out_lane === ln, req, "wide/lane",
            256'({out_wide, out_lane}), 256'({w, ln}));
        chk(out_data === exp, req, "data", out_data, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; clr(); in_op = OPA; in_wide = 1'b0; in_lane = 1'b0;
        in_tag = '0; in_a = '0; in_b = '0; in_sel = '0;
        repeat (3) step();
        chk(out_valid === 1'b0 && in_stall === 1'b0, "R10", "in reset",
            256'({out_valid, in_stall}), 256'd0);
        rst_n = 1'b1;
        step();
        chk(out_valid === 1'b0 && in_stall === 1'b0, "R10", "after reset",
            256'({out_valid, in_stall}), 256'd0);
    endtask

    task automatic t_wide_add();
        logic [255:0] a = mk_vec(7), b = mk_vec(11);
        put(OPA, 1'b1, 1'b0, 6'd5, a, b, '0);
        #1 chk(in_stall === 1'b0, "R1", "stall", 256'(in_stall), 256'd0);
        step(); clr();
        check_result("R1 R4", 6'd5, 1'b1, 1'b0, e_add(a, b, 8));
        step();
        chk(out_valid === 1'b0, "R1", "single result", 256'(out_valid), 256'd0);
    endtask

    task automatic t_wide_mul();
        logic [255:0] a = mk_vec(3), b = mk_vec(19);
        put(OPM, 1'b1, 1'b0, 6'd9, a, b, '0);
        step(); clr();
        chk(out_valid === 1'b0, "R2", "early 1", 256'(out_valid), 256'd0);
        step();
        chk(out_valid === 1'b0, "R2", "early 2", 256'(out_valid), 256'd0);
        step();
        check_result("R2", 6'd9, 1'b1, 1'b0, e_mul(a, b, 8));
    endtask

    task automatic t_shuffle();
        logic [255:0] a = mk_vec(23);
        logic [23:0]  rev, bc;
        for (int i = 0; i < 8; i++) begin
            rev[i*3 +: 3] = 3'(7 - i);
            bc[i*3 +: 3]  = 3'd6;
        end
        step();
        put(OPS, 1'b0, 1'b1, 6'd14, a, '0, rev);
        step();
        put(OPS, 1'b1, 1'b0, 6'd15, a, '0, bc);
        check_result("R3", 6'd14, 1'b1, 1'b0, e_shf(a, rev));
        step(); clr();
        check_result("R3", 6'd15, 1'b1, 1'b0, e_shf(a, bc));
    endtask

    task automatic t_narrow();
        logic [255:0] a = mk_vec(5), b = mk_vec(29);
        step();
        put(OPA, 1'b0, 1'b1, 6'd3, a, b, '0);
        step(); clr();
        check_result("R5", 6'd3, 1'b0, 1'b1, e_add(a, b, 4));
        put(OPM, 1'b0, 1'b0, 6'd4, a, b, '0);
        step(); clr();
        step(); step();
        check_result("R5", 6'd4, 1'b0, 1'b0, e_mul(a, b, 4));
    endtask

    task automatic t_lane_busy();
        logic [255:0] a = mk_vec(13), b = mk_vec(17);
        step();
        put(OPM, 1'b0, 1'b0, 6'd10, a, b, '0);
        step();
        put(OPA, 1'b1, 1'b0, 6'd11, a, b, '0);
        #1 chk(in_stall === 1'b1, "R6", "wide add blocked", 256'(in_stall), 256'd1);
        put(OPM, 1'b1, 1'b0, 6'd11, a, b, '0);
        #1 chk(in_stall === 1'b1, "R6", "wide mul blocked", 256'(in_stall), 256'd1);
        put(OPA, 1'b0, 1'b1, 6'd12, b, a, '0);
        #1 chk(in_stall === 1'b0, "R6", "other lane free", 256'(in_stall), 256'd0);
        step();
        check_result("R6", 6'd12, 1'b0, 1'b1, e_add(b, a, 4));
        put(OPA, 1'b0, 1'b0, 6'd13, a, b, '0);
        #1 chk(in_stall === 1'b1, "R6", "same lane blocked", 256'(in_stall), 256'd1);
        clr();
        step();
        check_result("R6", 6'd10, 1'b0, 1'b0, e_mul(a, b, 4));
        put(OPA, 1'b1, 1'b0, 6'd14, a, b, '0);
        #1 chk(in_stall === 1'b0, "R6", "lane released", 256'(in_stall), 256'd0);
        step(); clr();
        check_result("R6", 6'd14, 1'b1, 1'b0, e_add(a, b, 8));
    endtask

    task automatic t_slot_clash();
        logic [255:0] a = mk_vec(31), b = mk_vec(37);
        step();
        put(OPM, 1'b1, 1'b0, 6'd20, a, b, '0);
        step();
        put(OPA, 1'b1, 1'b0, 6'd21, a, b, '0);
        #1 chk(in_stall === 1'b0, "R7", "free slot", 256'(in_stall), 256'd0);
        step();
        check_result("R7", 6'd21, 1'b1, 1'b0, e_add(a, b, 8));
        put(OPS, 1'b1, 1'b0, 6'd22, a, '0, '0);
        #1 chk(in_stall === 1'b1, "R7", "shuffle clash", 256'(in_stall), 256'd1);
        put(OPA, 1'b1, 1'b0, 6'd23, b, b, '0);
        #1 chk(in_stall === 1'b1, "R7", "add clash", 256'(in_stall), 256'd1);
        step();
        check_result("R7", 6'd20, 1'b1, 1'b0, e_mul(a, b, 8));
        chk(in_stall === 1'b0, "R8", "stall drops", 256'(in_stall), 256'd0);
        step(); clr();
        check_result("R8", 6'd23, 1'b1, 1'b0, e_add(b, b, 8));
        step();
        chk(out_valid === 1'b0, "R8", "held op once", 256'(out_valid), 256'd0);
    endtask

    task automatic t_back_to_back();
        logic [255:0] a1 = mk_vec(41), a2 = mk_vec(43), a3 = mk_vec(47), b = mk_vec(53);
        step();
        put(OPM, 1'b1, 1'b0, 6'd30, a1, b, '0);
        step();
        put(OPM, 1'b1, 1'b0, 6'd31, a2, b, '0);
        #1 chk(in_stall === 1'b0, "R11", "second issue", 256'(in_stall), 256'd0);
        step();
        put(OPM, 1'b1, 1'b0, 6'd32, a3, b, '0);
        #1 chk(in_stall === 1'b0, "R11", "third issue", 256'(in_stall), 256'd0);
        step(); clr();
        check_result("R11", 6'd30, 1'b1, 1'b0, e_mul(a1, b, 8));
        step();
        check_result("R11", 6'd31, 1'b1, 1'b0, e_mul(a2, b, 8));
        step();
        check_result("R11", 6'd32, 1'b1, 1'b0, e_mul(a3, b, 8));
    endtask

    task automatic t_unused_op();
        bit seen = 1'b0;
        step();
        put(OPX, 1'b1, 1'b0, 6'd40, mk_vec(2), mk_vec(4), '0);
        #1 chk(in_stall === 1'b0, "R9", "no stall", 256'(in_stall), 256'd0);
        step(); clr();
        for (int i = 0; i < 4; i++) begin
            if (out_valid !== 1'b0) seen = 1'b1;
            step();
        end
        chk(!seen, "R9", "no result", 256'(seen), 256'd0);
    endtask

    initial begin
        t_reset();
        t_wide_add();
        t_wide_mul();
        t_shuffle();
        t_narrow();
        t_lane_busy();
        t_slot_clash();
        t_back_to_back();
        t_unused_op();
        step();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule